// File: doc/BRIEF.md
# Link Frame Header Codec and Continuation Arbiter

This block sits beside a full-duplex serial link that moves fixed-size frames between two processors. Each frame opens with a 32-bit control word. The block builds the outgoing control word from the local side's backlog and its receive-buffer state. It also decodes the incoming control word, keeps the remote side's flags, and tells the link sequencer whether another frame has to follow the one now finishing.

Both control words cross the wire in wire order: the lowest byte goes first, and each byte goes most significant bit first. Two reserved word values mark a frame as carrying nothing. All zeros clears the remembered remote state. All ones keeps the remembered flow-control state but drops size and MORE. When the local side has nothing to say, it sends the all-ones word. It stops doing so when its own buffer state differs from what it last told the peer.

Top module: `lnk_hdr_codec`

## Requirements
- R1: The native control word carries the valid byte count in bits 10:0, MORE in bit 12, the fixed next size 2044 in bits 26:16 and the local flow bit in bit 28. Every other bit is 0 on transmit.
- R2: `txWire` is `txHdr` in wire order, with bit 31 sent first: `txWire[31:24]=txHdr[7:0]`, `[23:16]=txHdr[15:8]`, `[15:8]=txHdr[23:16]`, `[7:0]=txHdr[31:24]`. `rxWire` is taken in the same order.
- R3: After reset, `remFlow`, `remMore` and `remSize` are 0, and `txAllowed` is 1. With `pendCount=0` and `rxFull=0`, `txHdr` is 0xFFFFFFFF and `contNext` is 0.
- R4: A received native word of 0x00000000 sets `remSize`, `remMore` and `remFlow` to 0 one cycle after `rxValid`.
- R5: A received native word of 0xFFFFFFFF sets `remSize` and `remMore` to 0 one cycle after `rxValid`. `remFlow` keeps its value.
- R6: Any other received word loads `remSize` from bits 10:0, `remMore` from bit 12 and `remFlow` from bit 28 one cycle after `rxValid`. All other bits are ignored.
- R7: The transmitted count is the smaller of `pendCount` and 2044. The transmitted MORE is 1 exactly when `pendCount` exceeds 2044.
- R8: While `remFlow` is 1, the transmitted count is 0 and `txAllowed` is 0.
- R9: `contNext` = (`rxFull`==0 AND `remMore`) OR (`remFlow`==0 AND local MORE).
- R10: `txHdr` is 0xFFFFFFFF when the count to send is 0, local MORE is 0, and `rxFull` equals the flow bit last advertised. The advertised bit is 0 at reset and takes `rxFull` on each `txSent` pulse.
- R11: The transmitted flow bit equals `rxFull`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pendCount | input | 16 | Local bytes waiting to be sent |
| rxFull | input | 1 | Local receive buffer cannot take data |
| rxWire | input | 32 | Received control word in wire order |
| rxValid | input | 1 | Strobe: rxWire holds a complete control word |
| txSent | input | 1 | Strobe: the current txHdr went out |
| txHdr | output | 32 | Outgoing control word, native bit order |
| txWire | output | 32 | Outgoing control word in wire order |
| remSize | output | 11 | Remote valid byte count |
| remMore | output | 1 | Remote MORE flag |
| remFlow | output | 1 | Remote cannot accept data |
| txAllowed | output | 1 | Local valid data may be sent |
| contNext | output | 1 | Another frame must follow |

## Verification
The bench drives the two reserved words after a header that set the remote flow bit. A design that mixed up their retention rules would either keep MORE alive or lose a flow stop the peer still holds. It sweeps all sixteen combinations of both sides' MORE and flow bits through the continuation check, which exposes a swapped operand or a wrong polarity. It also probes the size cap at exactly 2044 and above it, and checks that junk in the ignored bits does not reach the outputs. Finally, it toggles the local buffer state while idle, because a design that always idled with all ones would never tell the peer that a flow stop had been raised or lifted.

// File: rtl/lnk_hdr_pkg.sv
package lnk_hdr_pkg;
  // bit positions of the native control word
  localparam int MORE_BIT = 12;
  localparam int NEXT_LSB = 16;
  localparam int FLOW_BIT = 28;
  localparam int HDR_W    = 32;

  // strobes from control to datapath
  typedef struct packed {
    logic ldRemote;
    logic zeroRemote;
    logic txIdle;
  } hdrStrobe_t;
endpackage

// File: rtl/lnk_hdr_dp.sv
module lnk_hdr_dp
  import lnk_hdr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SIZE_W  = 11,
  parameter int PAYLOAD = 2044
) (
  input  logic               clk,
  input  logic               rstN,
  input  hdrStrobe_t         strb,
  input  logic [CNT_W-1:0]   pendCount,
  input  logic               rxFull,
  input  logic               remFlow,
  input  logic [HDR_W-1:0]   rxWire,
  output logic [HDR_W-1:0]   rxNative,
  output logic               localMore,
  output logic               sendZero,
  output logic [HDR_W-1:0]   txHdr,
  output logic [HDR_W-1:0]   txWire,
  output logic [SIZE_W-1:0]  remSize
);
  localparam int NBYTES = HDR_W / 8;
  localparam logic [SIZE_W-1:0] PAY_SZ = SIZE_W'(PAYLOAD);

  logic [SIZE_W-1:0] capped, sendSize;
  logic [HDR_W-1:0]  hdrBuilt;

  // byte reversal between native and wire order
  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign rxNative[8*b +: 8] = rxWire[8*(NBYTES-1-b) +: 8];
    assign txWire[8*b +: 8]   = txHdr[8*(NBYTES-1-b) +: 8];
  end

  assign localMore = pendCount > CNT_W'(PAYLOAD);
  assign capped    = localMore ? PAY_SZ : pendCount[SIZE_W-1:0];
  assign sendSize  = remFlow ? '0 : capped;
  assign sendZero  = (sendSize == '0);

  always_comb begin
    hdrBuilt = '0;
    hdrBuilt[SIZE_W-1:0]         = sendSize;
    hdrBuilt[MORE_BIT]           = localMore;
    hdrBuilt[NEXT_LSB +: SIZE_W] = PAY_SZ;
    hdrBuilt[FLOW_BIT]           = rxFull;
  end

  assign txHdr = strb.txIdle ? '1 : hdrBuilt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               remSize <= '0;
    else if (strb.zeroRemote) remSize <= '0;
    else if (strb.ldRemote)   remSize <= rxNative[SIZE_W-1:0];
  end

  // R8: a stopped peer never sees a nonzero count
  a_r8_blocked_zero: assert property (@(posedge clk) disable iff (!rstN)
    (remFlow && !strb.txIdle) |-> (txHdr[SIZE_W-1:0] == '0));
  // R7: count never beyond one payload
  a_r7_size_cap: assert property (@(posedge clk) disable iff (!rstN)
    !strb.txIdle |-> (txHdr[SIZE_W-1:0] <= PAY_SZ));
  // R4/R5: reserved words leave no remote count
  a_r4_reserved_size: assert property (@(posedge clk) disable iff (!rstN)
    (strb.zeroRemote) |=> (remSize == '0));
endmodule

// File: rtl/lnk_hdr_ctrl.sv
module lnk_hdr_ctrl
  import lnk_hdr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [HDR_W-1:0] rxNative,
  input  logic             rxFull,
  input  logic             txSent,
  input  logic             localMore,
  input  logic             sendZero,
  output hdrStrobe_t       strb,
  output logic             remFlow,
  output logic             remMore,
  output logic             contNext
);
  logic isZero, isOnes, advFlow;

  assign isZero = (rxNative == '0);
  assign isOnes = &rxNative;

  assign strb.ldRemote   = rxValid && !isZero && !isOnes;
  assign strb.zeroRemote = rxValid && (isZero || isOnes);
  assign strb.txIdle     = sendZero && !localMore && (rxFull == advFlow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remFlow <= 1'b0;
      remMore <= 1'b0;
    end else if (rxValid) begin
      if (isZero) begin
        remFlow <= 1'b0;
        remMore <= 1'b0;
      end else if (isOnes) begin
        remMore <= 1'b0;
      end else begin
        remFlow <= rxNative[FLOW_BIT];
        remMore <= rxNative[MORE_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       advFlow <= 1'b0;
    else if (txSent) advFlow <= rxFull;
  end

  assign contNext = (!rxFull && remMore) || (!remFlow && localMore);

  // R5: all-ones keeps the stop flag and drops MORE
  a_r5_ones_keep: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && isOnes) |=> (remFlow == $past(remFlow)) && !remMore);
  // R4: all-zeros clears the remote flags
  a_r4_zero_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && isZero) |=> !remFlow && !remMore);
  // R10: idle word only while nothing is pending
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strb.txIdle |-> !localMore && sendZero);
  // R6: flags hold without a received word
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> $stable(remFlow) && $stable(remMore));
endmodule

// File: rtl/lnk_hdr_codec.sv
module lnk_hdr_codec
  import lnk_hdr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SIZE_W  = 11,
  parameter int PAYLOAD = 2044
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  pendCount,
  input  logic              rxFull,
  input  logic [31:0]       rxWire,
  input  logic              rxValid,
  input  logic              txSent,
  output logic [31:0]       txHdr,
  output logic [31:0]       txWire,
  output logic [SIZE_W-1:0] remSize,
  output logic              remMore,
  output logic              remFlow,
  output logic              txAllowed,
  output logic              contNext
);
  hdrStrobe_t       strb;
  logic [HDR_W-1:0] rxNative;
  logic             localMore, sendZero;

  lnk_hdr_dp #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .PAYLOAD(PAYLOAD)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pendCount(pendCount),
    .rxFull(rxFull), .remFlow(remFlow), .rxWire(rxWire),
    .rxNative(rxNative), .localMore(localMore), .sendZero(sendZero),
    .txHdr(txHdr), .txWire(txWire), .remSize(remSize)
  );

  lnk_hdr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxNative(rxNative),
    .rxFull(rxFull), .txSent(txSent), .localMore(localMore),
    .sendZero(sendZero), .strb(strb), .remFlow(remFlow),
    .remMore(remMore), .contNext(contNext)
  );

  assign txAllowed = !remFlow;
endmodule

// File: tb/tb_lnk_hdr_codec.sv
`timescale 1ns/1ps
module tb_lnk_hdr_codec;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] pendCount = '0;
  logic        rxFull = 1'b0;
  logic [31:0] rxWire = '0;
  logic        rxValid = 1'b0;
  logic        txSent = 1'b0;
  logic [31:0] txHdr, txWire;
  logic [10:0] remSize;
  logic        remMore, remFlow, txAllowed, contNext;
  int          nChk = 0;
  int          nBad = 0;

  always #2 clk = ~clk;

  lnk_hdr_codec dut (
    .clk(clk), .rstN(rstN), .pendCount(pendCount), .rxFull(rxFull),
    .rxWire(rxWire), .rxValid(rxValid), .txSent(txSent), .txHdr(txHdr),
    .txWire(txWire), .remSize(remSize), .remMore(remMore),
    .remFlow(remFlow), .txAllowed(txAllowed), .contNext(contNext)
  );

  function automatic logic [31:0] toWire(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] mkHdr(input int sz, input bit more, input bit flow);
    logic [31:0] h;
    h = '0;
    h[10:0] = sz[10:0];
    h[12] = more;
    h[26:16] = 11'd2044;
    h[28] = flow;
    return h;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic recv(input logic [31:0] native);
    @(negedge clk);
    rxWire = toWire(native);
    rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R3 remFlow", 32'(remFlow), 0);
    chk("R3 remMore", 32'(remMore), 0);
    chk("R3 remSize", 32'(remSize), 0);
    chk("R3 txAllowed", 32'(txAllowed), 1);
    chk("R3 idle hdr", txHdr, 32'hFFFF_FFFF);
    chk("R3 contNext", 32'(contNext), 0);
  endtask

  task automatic t_sizing();
    pendCount = 16'd100; #1;
    chk("R1 hdr small", txHdr, mkHdr(100, 0, 0));
    chk("R2 wire order", txWire, toWire(mkHdr(100, 0, 0)));
    pendCount = 16'd2044; #1;
    chk("R7 exact payload", txHdr, mkHdr(2044, 0, 0));
    pendCount = 16'd3000; #1;
    chk("R7 capped more", txHdr, mkHdr(2044, 1, 0));
    chk("R9 local more", 32'(contNext), 1);
    pendCount = 16'd2045; #1;
    chk("R7 one over", txHdr, mkHdr(2044, 1, 0));
    rxFull = 1'b1; pendCount = 16'd7; #1;
    chk("R11 flow bit", txHdr, mkHdr(7, 0, 1));
    rxFull = 1'b0; pendCount = '0; #1;
  endtask

  task automatic t_receive();
    recv(mkHdr(500, 1, 1) | 32'h8100_2000);
    chk("R6 remSize", 32'(remSize), 500);
    chk("R6 remMore", 32'(remMore), 1);
    chk("R6 remFlow", 32'(remFlow), 1);
    chk("R8 txAllowed", 32'(txAllowed), 0);
    pendCount = 16'd3000; #1;
    chk("R8 zero count", txHdr, mkHdr(0, 1, 0));
    pendCount = '0; #1;
    recv(32'hFFFF_FFFF);
    chk("R5 size", 32'(remSize), 0);
    chk("R5 more", 32'(remMore), 0);
    chk("R5 flow kept", 32'(remFlow), 1);
    recv(32'h0000_0000);
    chk("R4 size", 32'(remSize), 0);
    chk("R4 more", 32'(remMore), 0);
    chk("R4 flow", 32'(remFlow), 0);
    chk("R4 txAllowed", 32'(txAllowed), 1);
  endtask

  task automatic t_continue();
    for (int rf = 0; rf < 2; rf++) begin
      for (int rm = 0; rm < 2; rm++) begin
        recv(mkHdr(10, rm[0], rf[0]));
        for (int lf = 0; lf < 2; lf++) begin
          for (int lm = 0; lm < 2; lm++) begin
            rxFull = lf[0];
            pendCount = lm[0] ? 16'd3000 : 16'd10;
            #1;
            chk("R9 continue", 32'(contNext),
                32'(((lf == 0) && (rm == 1)) || ((rf == 0) && (lm == 1))));
          end
        end
      end
    end
    rxFull = 1'b0; pendCount = '0;
    recv(32'h0000_0000);
  endtask

  task automatic t_idle();
    #1;
    chk("R10 idle", txHdr, 32'hFFFF_FFFF);
    rxFull = 1'b1; #1;
    chk("R10 stop announced", txHdr, mkHdr(0, 0, 1));
    @(negedge clk); txSent = 1'b1;
    @(negedge clk); txSent = 1'b0; #1;
    chk("R10 idle after stop", txHdr, 32'hFFFF_FFFF);
    rxFull = 1'b0; #1;
    chk("R10 release announced", txHdr, mkHdr(0, 0, 0));
    @(negedge clk); txSent = 1'b1;
    @(negedge clk); txSent = 1'b0; #1;
    chk("R10 idle after release", txHdr, 32'hFFFF_FFFF);
  endtask

  initial begin
    #10 rstN = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_sizing();
    t_receive();
    t_continue();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nBad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule